// File: doc/BRIEF.md
# Byte-Wide SPI Master with Half-Bit Step Sequencer

This block is the master side of a single-slave SPI link in clock mode 0 (clock idles low, data sampled on the rising edge). Each transaction moves one byte, most significant bit first. A sixteen-step sequencer spends two steps on every bit. The serial clock is low in the even steps and high in the odd steps. A parameter sets how many system clock cycles each step lasts.

Two enables pick the direction of a transaction. With the transmit enable high, the block captures the parallel input byte and shifts it out on the data-out pin. With the receive enable high, it assembles the bits seen on the data-in pin into a parallel output byte. Transmit wins when both enables are high. Dropping the active enable part way through abandons the transfer. Each direction has its own one-cycle completion pulse. Software-free logic upstream holds the enable high until that pulse appears and then lowers it.

Top module: `spi_byte_master`

## Requirements
- R1: While reset is asserted and after it is released, chip select is high, the serial clock is low, the serial data-out pin is low and both done pulses are low.
- R2: The serial clock is low in the idle state and in even steps, and high in odd steps. Each high phase lasts exactly HALF_DIV system cycles, and each completed transaction produces exactly 8 rising edges.
- R3: In transmit, the bit placed on the data-out pin at the k-th rising clock edge (k counted from 0) is the captured byte's bit 7-k. The pin holds steady for as long as the clock is high.
- R4: In receive, the data-in pin is sampled at each rising clock edge. After the byte completes, bit 7-k of the parallel output holds the value sampled at the k-th rising edge.
- R5: Chip select falls one step (HALF_DIV cycles) before step 0 begins and rises in the cycle after step 15 ends. It therefore stays low for 17*HALF_DIV system cycles in a completed transaction.
- R6: Each done pulse lasts exactly one system cycle. It is high in the first cycle that chip select is high again.
- R7: With both enables high at the start, a transmit transaction runs. Only the transmit done pulse fires, and the parallel output byte keeps its value.
- R8: Lowering the active direction's enable before the byte completes returns chip select high in the next cycle. No done pulse fires for that transaction.
- R9: The parallel input byte is captured when a transaction starts, so later changes to it do not alter the bits shifted out.
- R10: The parallel output byte changes only while a receive transaction is in progress. It holds its last value through idle periods and transmit transactions.
- R11: The data-out pin stays low when idle and during receive transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Requests and sustains a transmit transaction |
| rx_en | input | 1 | Requests and sustains a receive transaction |
| data_in | input | WIDTH | Byte to transmit, captured at transaction start |
| data_out | output | WIDTH | Byte assembled from the serial input |
| tx_done | output | 1 | One-cycle pulse when a transmitted byte completes |
| rx_done | output | 1 | One-cycle pulse when a received byte completes |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low slave select |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the slave |

## Verification
The bench targets four corner cases:
- Bit order, checked with the asymmetric bytes 0x01 and 0x80. A reversed shifter would swap them.
- Sampling edge, checked by a slave model that changes its data on every falling clock edge. A master that sampled on the falling edge would read each bit one position late.
- Overlap of the two enables, and an input byte rewritten mid-transfer. A wrong priority would raise the receive pulse or disturb the output byte. A missing capture register would leak the new byte onto the wire.
- An abort part way through the byte. A sequencer that ignored the dropped enable would hold chip select low and later raise a spurious done pulse.

// File: rtl/spi_byte_pkg.sv
// Shared definitions for the byte-wide SPI master.
// Assumes: the phase encoding is private to this block.
package spi_byte_pkg;

    // Sequencer phase: idle, lead-in with chip select low, and the stepping run.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_RUN  = 2'd2
    } seq_phase_e;

endpackage

// File: rtl/spi_half_tick.sv
// Half-period tick generator. It pulses tick once every HALF_DIV cycles
// while run is high, and restarts its count whenever run is low.
// Assumes: HALF_DIV >= 1.
module spi_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_every_cycle
            // Every active cycle is a step boundary.
            assign tick = run;
        end else begin : g_divided
            localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            // Count system cycles within the current half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_MAX) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            // Tick on the last cycle of each half period.
            assign tick = run && (cnt_q == CNT_MAX);
        end
    endgenerate
endmodule

// File: rtl/spi_step_seq.sv
// Transaction sequencer. It leaves idle when an enable is seen (transmit first),
// spends one lead-in step with chip select low, then walks steps 0..2*WIDTH-1.
// Each step lasts one tick period. It issues shift and sample strobes to the
// datapath and a one-cycle done pulse per direction. Dropping the active
// direction's enable aborts the transaction back to idle.
// Assumes: tick comes from spi_half_tick and runs only while the phase is not idle.
module spi_step_seq
    import spi_byte_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          tx_en,
    input  logic                          rx_en,
    output seq_phase_e                    phase,
    output logic                          dir_tx,
    output logic                          start,
    output logic                          tx_shift,
    output logic                          rx_sample,
    output logic                          tx_done,
    output logic                          rx_done
);
    localparam int STEPS  = 2 * WIDTH;
    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);
    localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);

    seq_phase_e        phase_q;
    logic [STEP_W-1:0] step_q;
    logic              dir_q;
    logic              txd_q;
    logic              rxd_q;
    logic              abort;
    logic              last;
    logic              adv;

    // Decode start, abort and the per-step strobes from the current state.
    always_comb begin
        start     = (phase_q == PH_IDLE) && (tx_en || rx_en);
        abort     = (phase_q != PH_IDLE) && (dir_q ? !tx_en : !rx_en);
        last      = (step_q == STEP_LAST);
        adv       = (phase_q == PH_RUN) && tick && !abort;
        tx_shift  = adv && dir_q && step_q[0] && !last;
        rx_sample = adv && !dir_q && !step_q[0];
    end

    // Advance phase and step, and raise the done pulse on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            dir_q   <= 1'b0;
            txd_q   <= 1'b0;
            rxd_q   <= 1'b0;
        end else begin
            txd_q <= 1'b0;
            rxd_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_LEAD;
                        dir_q   <= tx_en;
                        step_q  <= '0;
                    end
                end
                PH_LEAD: begin
                    if (abort) begin
                        phase_q <= PH_IDLE;
                    end else if (tick) begin
                        phase_q <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (abort) begin
                        phase_q <= PH_IDLE;
                    end else if (tick) begin
                        if (last) begin
                            phase_q <= PH_IDLE;
                            txd_q   <= dir_q;
                            rxd_q   <= !dir_q;
                        end else begin
                            step_q <= step_q + STEP_ONE;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = phase_q;
    assign dir_tx  = dir_q;
    assign tx_done = txd_q;
    assign rx_done = rxd_q;

    // The serial clock is high in odd steps of the run phase only.
    logic sck_int;
    assign sck_int = (phase_q == PH_RUN) && step_q[0];
endmodule

// File: rtl/spi_byte_datapath.sv
// Byte datapath. It captures the transmit byte at start, shifts it left
// (MSB first) on each transmit strobe, and shifts serial input bits in at the
// LSB on each receive sample, so the first bit ends in the MSB.
// Assumes: strobes come from spi_step_seq. MOSI is driven only during a
// transmit run.
module spi_byte_datapath
    import spi_byte_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_phase_e       phase,
    input  logic             dir_tx,
    input  logic             start,
    input  logic             tx_shift,
    input  logic             rx_sample,
    input  logic             miso,
    input  logic [WIDTH-1:0] data_in,
    output logic             mosi,
    output logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] tx_sh_q;
    logic [WIDTH-1:0] rx_sh_q;

    // Hold the outgoing byte: load at start, then shift on each new even step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
        end else if (start) begin
            tx_sh_q <= data_in;
        end else if (tx_shift) begin
            tx_sh_q <= {tx_sh_q[WIDTH-2:0], 1'b0};
        end
    end

    // Assemble the incoming byte, one bit per rising serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
        end else if (rx_sample) begin
            rx_sh_q <= {rx_sh_q[WIDTH-2:0], miso};
        end
    end

    assign mosi     = (phase == PH_RUN) && dir_tx && tx_sh_q[WIDTH-1];
    assign data_out = rx_sh_q;
endmodule

// File: rtl/spi_byte_master.sv
// Byte-wide SPI master, mode 0, single slave. It joins the half-period tick,
// the step sequencer and the byte datapath, and derives chip select and the
// serial clock from the sequencer state.
// Assumes: the requester holds tx_en or rx_en high until the matching done pulse.
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic             tx_done,
    output logic             rx_done,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi
);
    seq_phase_e phase;
    logic       dir_tx;
    logic       start;
    logic       tx_shift;
    logic       rx_sample;
    logic       tick;

    spi_half_tick #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase != PH_IDLE),
        .tick  (tick)
    );

    spi_step_seq #(
        .WIDTH (WIDTH)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .phase     (phase),
        .dir_tx    (dir_tx),
        .start     (start),
        .tx_shift  (tx_shift),
        .rx_sample (rx_sample),
        .tx_done   (tx_done),
        .rx_done   (rx_done)
    );

    spi_byte_datapath #(
        .WIDTH (WIDTH)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .dir_tx    (dir_tx),
        .start     (start),
        .tx_shift  (tx_shift),
        .rx_sample (rx_sample),
        .miso      (spi_miso),
        .data_in   (data_in),
        .mosi      (spi_mosi),
        .data_out  (data_out)
    );

    // Chip select is low whenever a transaction is in flight.
    assign spi_cs_n = (phase == PH_IDLE);
    // The serial clock follows the odd steps of the run phase.
    assign spi_sck  = u_seq.sck_int;
endmodule

// File: rtl/spi_byte_master_chk.sv
// Protocol checker for spi_byte_master. It watches the top-level ports only.
// Assumes: it is attached by the bind statement at the end of this file.
module spi_byte_master_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             rx_en,
    input logic [WIDTH-1:0] data_in,
    input logic [WIDTH-1:0] data_out,
    input logic             tx_done,
    input logic             rx_done,
    input logic             spi_miso,
    input logic             spi_cs_n,
    input logic             spi_sck,
    input logic             spi_mosi
);
    // R2: the serial clock idles low whenever the slave is deselected.
    p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R3: transmit data holds steady while the serial clock is high.
    p_mosi_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sck) |-> $stable(spi_mosi));

    // R6: each done pulse is a single cycle wide.
    p_tx_done_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    p_rx_done_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R6: a done pulse coincides with chip select returning high.
    p_done_at_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done || rx_done) |-> (spi_cs_n && $past(!spi_cs_n)));

    // R7: only one direction completes per transaction.
    p_done_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && rx_done));

    // R10: the parallel output cannot move while the slave is deselected.
    p_data_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> $stable(data_out));

    // R11: the data-out pin is low while idle.
    p_mosi_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);
endmodule

bind spi_byte_master spi_byte_master_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_spi_byte_master.sv
// Scoreboard bench: driver tasks queue expected bytes, a negedge monitor
// observes the SPI pins and done pulses and compares against the queues.
module tb_spi_byte_master;
    localparam int W    = 8;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_en = 1'b0;
    logic         rx_en = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;
    logic         tx_done;
    logic         rx_done;
    logic         spi_miso = 1'b0;
    logic         spi_cs_n;
    logic         spi_sck;
    logic         spi_mosi;

    always #2.5 clk = ~clk;

    spi_byte_master #(.WIDTH(W), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .data_in(data_in), .data_out(data_out), .tx_done(tx_done),
        .rx_done(rx_done), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    int n_chk = 0;
    int n_fail = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    logic [W-1:0] tx_q[$];
    logic [W-1:0] rx_q[$];
    logic [W-1:0] slave_byte = '0;
    bit abort_expected = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: slave model plus scoreboard comparison.
    logic         prev_cs = 1'b1;
    logic         prev_sck = 1'b0;
    logic         prev_txd = 1'b0;
    logic         prev_rxd = 1'b0;
    logic [W-1:0] bits = '0;
    logic [W-1:0] slave_sh = '0;
    int           cs_low = 0;
    int           nrise = 0;
    int           hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n) begin
                cs_low = 0; nrise = 0; bits = '0;
                slave_sh = slave_byte;
                spi_miso = slave_sh[W-1];
            end
            if (!spi_cs_n) cs_low++;
            if (!prev_sck && spi_sck) begin
                bits = {bits[W-2:0], spi_mosi};
                nrise++;
                hi_run = 0;
            end
            if (spi_sck) hi_run++;
            if (prev_sck && !spi_sck) begin
                chk(hi_run == HALF, "R2", "sck high width", hi_run, HALF);
                slave_sh = {slave_sh[W-2:0], 1'b0};
                spi_miso = slave_sh[W-1];
            end
            if (!prev_cs && spi_cs_n && !abort_expected) begin
                chk(cs_low == 17 * HALF, "R5", "cs low cycles", cs_low, 17 * HALF);
                chk(nrise == W, "R2", "sck rising edges", nrise, W);
            end
            if (tx_done) begin
                tx_cnt++;
                chk(spi_cs_n == 1'b1, "R6", "cs high at tx_done", spi_cs_n, 1);
                if (tx_q.size() == 0) chk(1'b0, "R3", "unexpected tx_done", 1, 0);
                else begin
                    logic [W-1:0] e;
                    e = tx_q.pop_front();
                    chk(bits == e, "R3", "mosi byte", bits, e);
                end
            end
            if (rx_done) begin
                rx_cnt++;
                chk(spi_cs_n == 1'b1, "R6", "cs high at rx_done", spi_cs_n, 1);
                chk(bits == '0, "R11", "mosi during receive", bits, 0);
                if (rx_q.size() == 0) chk(1'b0, "R4", "unexpected rx_done", 1, 0);
                else begin
                    logic [W-1:0] e;
                    e = rx_q.pop_front();
                    chk(data_out == e, "R4", "data_out byte", data_out, e);
                end
            end
            if (prev_txd) chk(!tx_done, "R6", "tx_done width", tx_done, 0);
            if (prev_rxd) chk(!rx_done, "R6", "rx_done width", rx_done, 0);
        end
        prev_cs  = spi_cs_n;
        prev_sck = spi_sck;
        prev_txd = tx_done;
        prev_rxd = rx_done;
    end

    task automatic do_tx(input logic [W-1:0] d, input bit scramble);
        logic [W-1:0] keep;
        keep = data_out;
        tx_q.push_back(d);
        @(negedge clk);
        data_in = d;
        tx_en = 1'b1;
        if (scramble) begin
            repeat (10) @(negedge clk);
            data_in = ~d;  // R9: must not reach the wire
        end
        do @(negedge clk); while (!tx_done);
        tx_en = 1'b0;
        chk(data_out == keep, "R10", "data_out across transmit", data_out, keep);
    endtask

    task automatic do_rx(input logic [W-1:0] d);
        rx_q.push_back(d);
        @(negedge clk);
        slave_byte = d;
        rx_en = 1'b1;
        do @(negedge clk); while (!rx_done);
        rx_en = 1'b0;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1", "cs in reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1", "sck in reset", spi_sck, 0);
        chk(spi_mosi == 1'b0, "R1", "mosi in reset", spi_mosi, 0);
        chk(!tx_done && !rx_done, "R1", "done in reset", {tx_done, rx_done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !spi_mosi, "R1", "idle after reset",
            {spi_cs_n, spi_sck, spi_mosi}, 3'b100);

        // R3: asymmetric patterns catch bit-order errors.
        do_tx(8'hA5, 1'b0);
        do_tx(8'h01, 1'b0);
        do_tx(8'h80, 1'b0);

        // R4: receive with the slave changing data on falling edges.
        do_rx(8'h3C);
        do_rx(8'h81);
        do_rx(8'hE7);

        // R9: input byte rewritten mid-transfer.
        do_tx(8'h5A, 1'b1);

        // R7: both enables high, transmit wins.
        begin
            logic [W-1:0] keep;
            int rx_before;
            keep = data_out;
            rx_before = rx_cnt;
            tx_q.push_back(8'hC6);
            @(negedge clk);
            data_in = 8'hC6;
            slave_byte = 8'h00;
            tx_en = 1'b1;
            rx_en = 1'b1;
            do @(negedge clk); while (!tx_done);
            tx_en = 1'b0;
            rx_en = 1'b0;
            repeat (3) @(negedge clk);
            chk(rx_cnt == rx_before, "R7", "no rx_done on overlap", rx_cnt, rx_before);
            chk(data_out == keep, "R7", "data_out kept on overlap", data_out, keep);
        end

        // R8: abort part way through.
        begin
            int tx_before;
            tx_before = tx_cnt;
            abort_expected = 1'b1;
            @(negedge clk);
            data_in = 8'h99;
            tx_en = 1'b1;
            repeat (30) @(negedge clk);
            chk(spi_cs_n == 1'b0, "R8", "cs low mid-transfer", spi_cs_n, 0);
            tx_en = 1'b0;
            @(negedge clk);
            chk(spi_cs_n == 1'b1, "R8", "cs high after abort", spi_cs_n, 1);
            repeat (80) @(negedge clk);
            chk(tx_cnt == tx_before, "R8", "no tx_done after abort", tx_cnt, tx_before);
            abort_expected = 1'b0;
        end

        // Recovery after the abort.
        do_tx(8'hC3, 1'b0);

        // R10: output byte keeps last received value through idle.
        repeat (20) @(negedge clk);
        chk(data_out == 8'hE7, "R10", "data_out in idle", data_out, 8'hE7);
        chk(tx_q.size() == 0, "R3", "tx queue drained", tx_q.size(), 0);
        chk(rx_q.size() == 0, "R4", "rx queue drained", rx_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule